// File: doc/BRIEF.md
# Instruction Address Sequencer with Return Stack

This block produces the 10-bit instruction address of a small soft microcontroller, one address per clock. Every cycle the decoder hands it one flow-control command, a condition selector, a target address and the present carry and zero flags. The block then picks the address for the next cycle: the next sequential address, a jump target, a subroutine entry, or a saved return address.

It keeps a 31-frame return stack and an interrupt-enable bit. When interrupts are enabled and the request line is high, the block takes the interrupt in place of the command presented that cycle. It saves carry and zero, stacks the address of the instruction that was set aside, clears the enable bit and moves to the vector at 0x3FF. It raises the acknowledge for the one cycle spent at the vector.

The two interrupt-return commands resume at the stacked address exactly, with no increment. In the following cycle they raise a restore strobe, with the saved carry and zero presented alongside it. The ALU, program memory and instruction decoding sit outside this block.

Top module: `prog_seq`

## Requirements
- R1: While reset is low at a clock edge, the block clears the program counter to 0, clears the interrupt enable, empties the return stack (pointer 0) and drives both the acknowledge and restore strobes low.
- R2: Command code 0 (step) loads the program counter plus one, and 0x3FF steps to 0x000.
- R3: Command code 1 (jump) loads the target when the condition holds, and otherwise loads the program counter plus one. Condition codes: bit 2 clear means always; 4 means carry set, 5 carry clear, 6 zero set, 7 zero clear.
- R4: Command code 2 (call), when its condition holds, stacks the current program counter and loads the target. When the condition fails it only steps by one and stacks nothing.
- R5: Command code 3 (return), when its condition holds, loads the most recently stacked address plus one and pops it. When the condition fails it only steps by one.
- R6: Command codes 4 and 5 (interrupt return) ignore the condition. Each pops the stack and loads the popped address unchanged. Code 4 sets the enable bit and code 5 clears it. In the next cycle the restore strobe is high and the saved-carry and saved-zero outputs show the flags captured at interrupt entry.
- R7: Command code 6 sets the interrupt enable and code 7 clears it. Both also step the program counter by one.
- R8: With the enable set and the request high at an edge, the command is ignored. The current program counter is stacked, carry and zero are saved, the enable is cleared and the program counter becomes 0x3FF. The acknowledge is high for exactly that next cycle.
- R9: With the enable clear, a high request has no effect: the command executes normally and the acknowledge stays low.
- R10: The return stack holds 31 frames, and its pointer wraps modulo 31 on both overflow and underflow. Popping past empty therefore returns the frames again, beginning with the one written by the 31st push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_i | input | 3 | Flow-control command code |
| cond_i | input | 3 | Condition selector |
| target_i | input | 10 | Jump or call target address |
| carry_i | input | 1 | Current carry flag |
| zero_i | input | 1 | Current zero flag |
| irq_i | input | 1 | Interrupt request |
| pc_o | output | 10 | Program counter (instruction address) |
| irq_ack_o | output | 1 | Interrupt acknowledge, one cycle at the vector |
| irq_en_o | output | 1 | Interrupt enable state |
| restore_o | output | 1 | High the cycle after an interrupt return |
| carry_saved_o | output | 1 | Carry value saved at interrupt entry |
| zero_saved_o | output | 1 | Zero value saved at interrupt entry |

## Verification
The bench sweeps every condition code against all four flag combinations for a jump. A decoder with a swapped or inverted condition would land on the wrong address in one of those 32 cases. It fills the stack past its 31 frames and pops 33 times, so a pointer that wraps at 32 instead of 31, or wraps wrongly on underflow, returns the wrong addresses. Interrupt checks confirm that an interrupt return skips the +1 a normal return applies, that a held request is not taken twice, and that the command presented during entry is discarded. A design that executed that command or re-entered would leave the counter off 0x3FF, or raise the acknowledge for more than one cycle.

// File: rtl/prog_seq_pkg.sv
// Shared command and condition encodings for the instruction address sequencer.
package prog_seq_pkg;

    typedef enum logic [2:0] {
        CMD_STEP     = 3'd0,
        CMD_JUMP     = 3'd1,
        CMD_CALL     = 3'd2,
        CMD_RET      = 3'd3,
        CMD_RETI_EN  = 3'd4,
        CMD_RETI_DIS = 3'd5,
        CMD_INT_EN   = 3'd6,
        CMD_INT_DIS  = 3'd7
    } cmd_t;

    // Bit 2 clear selects "always"; bits 1:0 pick the flag test otherwise.
    localparam logic [1:0] CC_CARRY   = 2'd0;
    localparam logic [1:0] CC_NCARRY  = 2'd1;
    localparam logic [1:0] CC_ZERO    = 2'd2;
    localparam logic [1:0] CC_NZERO   = 2'd3;

endpackage

// File: rtl/seq_cond.sv
// Condition evaluator.
// Does: reports whether the selected flag test holds this cycle.
// Assumes: flags are the current architectural carry and zero.
module seq_cond (
    input  logic [2:0] cond_i,
    input  logic       carry_i,
    input  logic       zero_i,
    output logic       ok_o
);
    import prog_seq_pkg::*;

    // Decode the selector into a pass/fail result.
    always_comb begin
        if (!cond_i[2]) begin
            ok_o = 1'b1;
        end else begin
            case (cond_i[1:0])
                CC_CARRY:  ok_o = carry_i;
                CC_NCARRY: ok_o = !carry_i;
                CC_ZERO:   ok_o = zero_i;
                default:   ok_o = !zero_i;
            endcase
        end
    end
endmodule

// File: rtl/seq_stack.sv
// Return address stack.
// Does: holds DEPTH return addresses; push writes at pointer+1 and advances,
//       pop reads the entry under the pointer and retreats; pointer wraps mod DEPTH.
// Assumes: push and pop are never requested in the same cycle.
module seq_stack #(
    parameter int DEPTH = 31,
    parameter int AW    = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic          pop_i,
    input  logic [AW-1:0] push_data_i,
    output logic [AW-1:0] top_o
);
    localparam int          PW   = $clog2(DEPTH);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [AW-1:0] frames [DEPTH];
    logic [PW-1:0] ptr_q;
    logic [PW-1:0] ptr_up;
    logic [PW-1:0] ptr_dn;

    // Wrapped neighbours of the pointer.
    always_comb begin
        ptr_up = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        ptr_dn = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
    end

    assign top_o = frames[ptr_q];

    // Pointer update; reset empties the stack.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (push_i) begin
            ptr_q <= ptr_up;
        end else if (pop_i) begin
            ptr_q <= ptr_dn;
        end
    end

    // Frame storage write on push.
    always_ff @(posedge clk) begin
        if (push_i) begin
            frames[ptr_up] <= push_data_i;
        end
    end

    AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST) else $error("stack pointer out of range"); // R10
    AST_PUSH_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(push_i && pop_i)) else $error("push and pop together"); // R4
endmodule

// File: rtl/seq_irq_ctl.sv
// Interrupt control.
// Does: holds the enable bit and saved flags, decides interrupt entry,
//       and produces the acknowledge and restore strobes.
// Assumes: the request is a level sampled at each edge.
module seq_irq_ctl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] cmd_i,
    input  logic       irq_i,
    input  logic       carry_i,
    input  logic       zero_i,
    output logic       take_o,
    output logic       en_o,
    output logic       ack_o,
    output logic       restore_o,
    output logic       carry_saved_o,
    output logic       zero_saved_o
);
    import prog_seq_pkg::*;

    cmd_t cmd;
    logic en_q, ack_q, rst_q, cs_q, zs_q;
    logic is_reti;

    assign cmd     = cmd_t'(cmd_i);
    assign take_o  = en_q && irq_i;
    assign is_reti = (cmd == CMD_RETI_EN) || (cmd == CMD_RETI_DIS);

    // Enable bit: entry clears, commands set or clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= 1'b0;
        end else if (take_o) begin
            en_q <= 1'b0;
        end else begin
            case (cmd)
                CMD_RETI_EN, CMD_INT_EN:   en_q <= 1'b1;
                CMD_RETI_DIS, CMD_INT_DIS: en_q <= 1'b0;
                default:                   en_q <= en_q;
            endcase
        end
    end

    // Flag preservation at entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q <= 1'b0;
            zs_q <= 1'b0;
        end else if (take_o) begin
            cs_q <= carry_i;
            zs_q <= zero_i;
        end
    end

    // One-cycle strobes for entry and interrupt return.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            rst_q <= 1'b0;
        end else begin
            ack_q <= take_o;
            rst_q <= !take_o && is_reti;
        end
    end

    assign en_o          = en_q;
    assign ack_o         = ack_q;
    assign restore_o     = rst_q;
    assign carry_saved_o = cs_q;
    assign zero_saved_o  = zs_q;

    AST_ACK_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |-> !en_q) else $error("enable left set after entry"); // R8
    AST_NO_ACK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_i && !en_q) |=> !ack_q) else $error("ack while disabled"); // R9
    AST_RETI_EN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_o && cmd == CMD_RETI_EN) |=> (en_q && rst_q)) else $error("reti enable"); // R6
endmodule

// File: rtl/prog_seq.sv
// Instruction address sequencer (top).
// Does: registers the program counter and chooses its next value from
//       step, jump, call, return, interrupt return and interrupt entry.
// Assumes: one command per clock, already decoded; interrupt wins over command.
module prog_seq #(
    parameter int AW          = 10,
    parameter int STACK_DEPTH = 31
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cmd_i,
    input  logic [2:0]    cond_i,
    input  logic [AW-1:0] target_i,
    input  logic          carry_i,
    input  logic          zero_i,
    input  logic          irq_i,
    output logic [AW-1:0] pc_o,
    output logic          irq_ack_o,
    output logic          irq_en_o,
    output logic          restore_o,
    output logic          carry_saved_o,
    output logic          zero_saved_o
);
    import prog_seq_pkg::*;

    localparam logic [AW-1:0] VECTOR = '1;

    cmd_t          cmd;
    logic [AW-1:0] pc_q, pc_nxt, top;
    logic          cond_ok, take, push, pop;

    assign cmd = cmd_t'(cmd_i);

    seq_cond u_cond (
        .cond_i  (cond_i),
        .carry_i (carry_i),
        .zero_i  (zero_i),
        .ok_o    (cond_ok)
    );

    seq_irq_ctl u_irq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_i         (cmd_i),
        .irq_i         (irq_i),
        .carry_i       (carry_i),
        .zero_i        (zero_i),
        .take_o        (take),
        .en_o          (irq_en_o),
        .ack_o         (irq_ack_o),
        .restore_o     (restore_o),
        .carry_saved_o (carry_saved_o),
        .zero_saved_o  (zero_saved_o)
    );

    seq_stack #(.DEPTH(STACK_DEPTH), .AW(AW)) u_stack (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (push),
        .pop_i       (pop),
        .push_data_i (pc_q),
        .top_o       (top)
    );

    // Next-address selection and stack requests.
    always_comb begin
        push   = 1'b0;
        pop    = 1'b0;
        pc_nxt = pc_q + 1'b1;
        if (take) begin
            push   = 1'b1;
            pc_nxt = VECTOR;
        end else begin
            case (cmd)
                CMD_JUMP: if (cond_ok) pc_nxt = target_i;
                CMD_CALL: if (cond_ok) begin
                    push   = 1'b1;
                    pc_nxt = target_i;
                end
                CMD_RET: if (cond_ok) begin
                    pop    = 1'b1;
                    pc_nxt = top + 1'b1;
                end
                CMD_RETI_EN, CMD_RETI_DIS: begin
                    pop    = 1'b1;
                    pc_nxt = top;
                end
                default: pc_nxt = pc_q + 1'b1;
            endcase
        end
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_nxt;
    end

    assign pc_o = pc_q;

    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd0 && !(irq_en_o && irq_i)) |=> pc_o == $past(pc_o) + 1'b1)
        else $error("step did not add one"); // R2
    AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == 3'd1 && !cond_i[2] && !(irq_en_o && irq_i)) |=> pc_o == $past(target_i))
        else $error("jump did not load target"); // R3
    AST_ENTRY_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en_o && irq_i) |=> (pc_o == VECTOR && irq_ack_o))
        else $error("entry did not reach vector"); // R8
endmodule

// File: tb/sim_prog_seq.sv
`timescale 1ns/1ps
module sim_prog_seq;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] cmd, cond;
    logic [9:0] target;
    logic       cf, zf, irq;
    logic [9:0] pc;
    logic       ack, en, rest, cs, zs;
    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prog_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .cond_i(cond), .target_i(target),
        .carry_i(cf), .zero_i(zf), .irq_i(irq), .pc_o(pc), .irq_ack_o(ack),
        .irq_en_o(en), .restore_o(rest), .carry_saved_o(cs), .zero_saved_o(zs)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Apply one command at a falling edge and wait to the next falling edge.
    task automatic step(input logic [2:0] c, input logic [2:0] cc, input logic [9:0] t,
                        input logic fc, input logic fz, input logic rq);
        cmd = c; cond = cc; target = t; cf = fc; zf = fz; irq = rq;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; cmd = 0; cond = 0; target = 0; cf = 0; zf = 0; irq = 0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        chk("R1 pc", pc, 0); chk("R1 en", en, 0);
        chk("R1 ack", ack, 0); chk("R1 restore", rest, 0);

        // R2 sequential stepping and wrap
        for (int i = 1; i <= 3; i++) begin
            step(0, 0, 10'h155, 0, 0, 0);
            chk("R2 step", pc, i);
        end
        step(1, 0, 10'h3FF, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R2 wrap", pc, 0);

        // R3 condition sweep for jumps
        for (int cc = 0; cc < 8; cc++) begin
            for (int f = 0; f < 4; f++) begin
                logic c_f, z_f, ok;
                c_f = f[0]; z_f = f[1];
                if (cc < 4) ok = 1;
                else if (cc == 4) ok = c_f;
                else if (cc == 5) ok = !c_f;
                else if (cc == 6) ok = z_f;
                else ok = !z_f;
                step(1, 0, 10'h100, 0, 0, 0);
                step(1, 3'(cc), 10'h2AA, c_f, z_f, 0);
                chk("R3 jump cond", pc, ok ? 10'h2AA : 10'h101);
            end
        end

        // R4 and R5 conditional calls and returns
        step(1, 0, 10'h050, 0, 0, 0);
        step(2, 4, 10'h300, 0, 0, 0);
        chk("R4 call fail", pc, 10'h051);
        step(2, 6, 10'h200, 0, 1, 0);
        chk("R4 call taken", pc, 10'h200);
        step(3, 7, 0, 0, 1, 0);
        chk("R5 ret fail", pc, 10'h201);
        step(3, 6, 0, 0, 1, 0);
        chk("R5 ret taken", pc, 10'h052);

        // R10 stack depth and wrap
        do_reset();
        for (int k = 1; k <= 31; k++) begin
            step(2, 0, 10'(10 * k), 0, 0, 0);
            chk("R4 call chain", pc, 10 * k);
        end
        for (int j = 1; j <= 31; j++) begin
            step(3, 0, 0, 0, 0, 0);
            chk("R10 pop order", pc, 10 * (31 - j) + 1);
        end
        step(3, 0, 0, 0, 0, 0);
        chk("R10 underflow wrap", pc, 301);
        step(3, 0, 0, 0, 0, 0);
        chk("R10 underflow next", pc, 291);

        // R7, R8, R6 interrupt flow
        do_reset();
        step(1, 0, 10'h140, 0, 0, 0);
        step(6, 0, 0, 0, 0, 0);
        chk("R7 enable pc", pc, 10'h141); chk("R7 enable bit", en, 1);
        step(1, 0, 10'h123, 1, 0, 1);
        chk("R8 vector", pc, 10'h3FF); chk("R8 ack", ack, 1); chk("R8 masked", en, 0);
        step(0, 0, 0, 0, 0, 1);
        chk("R8 ack one cycle", ack, 0); chk("R9 held req pc", pc, 0);
        step(0, 0, 0, 0, 0, 0);
        step(4, 0, 0, 0, 1, 0);
        chk("R6 reti addr", pc, 10'h141); chk("R6 reti en", en, 1);
        chk("R6 restore", rest, 1); chk("R6 carry", cs, 1); chk("R6 zero", zs, 0);
        step(0, 0, 0, 0, 0, 0);
        chk("R6 restore drop", rest, 0); chk("R6 resume", pc, 10'h142);
        step(0, 0, 0, 0, 1, 1);
        chk("R8 second entry", pc, 10'h3FF);
        step(5, 0, 0, 1, 0, 0);
        chk("R6 reti dis addr", pc, 10'h142); chk("R6 reti dis en", en, 0);
        chk("R6 carry 2", cs, 0); chk("R6 zero 2", zs, 1);
        step(1, 0, 10'h0AB, 0, 0, 1);
        chk("R9 ignored pc", pc, 10'h0AB); chk("R9 no ack", ack, 0);
        step(6, 0, 0, 0, 0, 0);
        step(7, 0, 0, 0, 0, 0);
        chk("R7 disable bit", en, 0); chk("R7 disable pc", pc, 10'h0AD);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule